// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port with Change Interrupt

This block is an eight-pin general-purpose port. A small register file behind a synchronous read/write interface sets its behaviour. Each pin is either an output, driven from a bit of the output-data register, or an input, with its driver released.

Input levels pass through a two-flop synchronizer. Reads of the pin-level register return those synchronized levels, optionally inverted per bit. Every such read also stores the raw synchronized levels as a reference snapshot.

While any input-direction pin differs from that snapshot, an active-low interrupt line is pulled low. The line releases when the pins go back to the snapshot levels or when the pin-level register is read again. The pad drivers are not part of the block. It exposes per-pin drive-enable and drive-value signals for a pad ring to use.

Top module: `gpio_port`

## Requirements
- R1: On reset the direction register reads 0xFF (every pin an input), output data reads 0xFF, inversion reads 0x00, `pin_oe` is 0x00, `irq_n` is 1 and `rd_data` is 0x00.
- R2: `pin_oe[i]` is 1 exactly when direction bit i is 0, and `pin_out` always equals the output-data register.
- R3: Writes to index 1 (output data), index 2 (inversion) and index 3 (direction) take effect at the strobing clock edge. A read strobe at index k places that register on `rd_data` at the next edge, and `rd_data` holds until the next read.
- R4: A write to index 0 changes no register and no output.
- R5: A read of index 0 returns the synchronized pin levels XOR the inversion register. The synchronizer has two flops, so a pin change first appears in a read whose strobe is sampled at the third edge after the change.
- R6: `irq_n` is 0 exactly when some pin with direction bit 1 has a synchronized level different from its snapshot bit. Pins set as outputs never cause the interrupt.
- R7: When the pins return to the snapshot levels, `irq_n` returns to 1 with no register access.
- R8: A read of index 0 loads the snapshot with the synchronized levels at that edge, so `irq_n` is 1 from that edge while the pins hold still.
- R9: Turning a pin from output to input while its level differs from its snapshot bit raises the interrupt. This case is not masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register index: 0 pins, 1 output data, 2 inversion, 3 direction |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_oe | output | 8 | Per-pin drive enable (1 = drive) |
| pin_out | output | 8 | Per-pin drive value |
| irq_n | output | 1 | Active-low interrupt, 0 = pull line low |

## Verification
Register writes show on `pin_oe` and `pin_out` right after the strobing edge. Read data appears one edge after the strobe. A pin change reaches the synchronized value, and so the interrupt, two edges later. The interrupt is combinational from the synchronizer, snapshot and direction registers, so it follows a snapshot-loading read at that same edge. The bench drives inputs just after a falling edge and samples at a later falling edge, placed by those counts. A directed case reads at the second and third edges after a pin change to pin down the synchronizer depth.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PINS    = 8;
    localparam int IDX_W   = 2;
    localparam int SYNC_N  = 2;

    typedef logic [PINS-1:0] pins_t;

    typedef enum logic [IDX_W-1:0] {
        IDX_LEVEL = 2'd0,
        IDX_DRIVE = 2'd1,
        IDX_INV   = 2'd2,
        IDX_DIR   = 2'd3
    } reg_idx_e;

    typedef struct packed {
        pins_t drive;
        pins_t inv;
        pins_t dir;
    } ctrl_t;

    localparam pins_t DRIVE_RST = '1;
    localparam pins_t INV_RST   = '0;
    localparam pins_t DIR_RST   = '1;

    function automatic pins_t watched_diff(input pins_t live, input pins_t snap,
                                           input pins_t dir);
        return (live ^ snap) & dir;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] addr,
    input  pins_t            wr_data,
    output ctrl_t            regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs.drive <= DRIVE_RST;
            regs.inv   <= INV_RST;
            regs.dir   <= DIR_RST;
        end else if (wr_en) begin
            unique case (reg_idx_e'(addr))
                IDX_DRIVE: regs.drive <= wr_data;
                IDX_INV:   regs.inv   <= wr_data;
                IDX_DIR:   regs.dir   <= wr_data;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  pins_t live,
    input  pins_t dir,
    output logic  active
);
    pins_t snap;

    always_ff @(posedge clk) begin
        if (rst)       snap <= '0;
        else if (load) snap <= live;
    end

    assign active = |watched_diff(live, snap, dir);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] addr,
    input  logic             wr_en,
    input  logic [PINS-1:0]  wr_data,
    input  logic             rd_en,
    output logic [PINS-1:0]  rd_data,
    input  logic [PINS-1:0]  pin_in,
    output logic [PINS-1:0]  pin_oe,
    output logic [PINS-1:0]  pin_out,
    output logic             irq_n
);
    pins_t pin_sync;
    ctrl_t regs;
    logic  irq_active;
    logic  level_read;

    gpio_sync #(.W(PINS), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .regs    (regs)
    );

    assign level_read = rd_en && (reg_idx_e'(addr) == IDX_LEVEL);

    gpio_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .load   (level_read),
        .live   (pin_sync),
        .dir    (regs.dir),
        .active (irq_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (reg_idx_e'(addr))
                IDX_LEVEL: rd_data <= pin_sync ^ regs.inv;
                IDX_DRIVE: rd_data <= regs.drive;
                IDX_INV:   rd_data <= regs.inv;
                IDX_DIR:   rd_data <= regs.dir;
                default:   rd_data <= '0;
            endcase
        end
    end

    assign pin_oe  = ~regs.dir;
    assign pin_out = regs.drive;
    assign irq_n   = ~irq_active;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] addr,
    input logic             wr_en,
    input logic [PINS-1:0]  wr_data,
    input logic             rd_en,
    input logic [PINS-1:0]  pin_oe,
    input logic [PINS-1:0]  pin_out,
    input logic             irq_n,
    input logic [PINS-1:0]  pin_sync
);
    a_r1_reset_all_inputs: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && irq_n == 1'b1));

    a_r2_dir_write_sets_oe: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd3) |=> (pin_oe == ~$past(wr_data)));

    a_r4_level_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0) |=> ($stable(pin_oe) && $stable(pin_out)));

    a_r6_outputs_never_interrupt: assert property (@(posedge clk) disable iff (rst)
        (irq_n == 1'b0) |-> (pin_oe != '1));

    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd0) |=> (irq_n || (pin_sync != $past(pin_sync))));
endmodule

bind gpio_port gpio_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out),
    .irq_n    (irq_n),
    .pin_sync (pin_sync)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;
    logic       irq_n;

    int checks = 0;
    int failures = 0;
    logic [7:0] got;

    always #2.5 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .irq_n(irq_n)
    );

    // row: {read after, direction, pins, expected irq_n}
    localparam logic [17:0] VEC [8] = '{
        {1'b1, 8'hFF, 8'h01, 1'b0},  // R6 input change
        {1'b0, 8'hFF, 8'h01, 1'b1},  // R8 snapshot matches
        {1'b0, 8'h0F, 8'h81, 1'b1},  // R6 output pin ignored
        {1'b0, 8'h0F, 8'h83, 1'b0},  // R6 input pin 1 changes
        {1'b0, 8'h0F, 8'h81, 1'b1},  // R7 revert clears
        {1'b1, 8'hFF, 8'h81, 1'b0},  // R9 output-to-input mismatch
        {1'b1, 8'hF0, 8'h7E, 1'b0},  // R6 upper nibble differs
        {1'b0, 8'h00, 8'h00, 1'b1}   // R6 all outputs
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; pin_in = '0; wr_en = 1'b0; rd_en = 1'b0;
        cyc(3);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        cyc(1);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(1);
        do_reset();
        // R1 reset defaults
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        rd(2'd3, got); check("R1 dir", got, 8'hFF);
        rd(2'd1, got); check("R1 drive", got, 8'hFF);
        rd(2'd2, got); check("R1 inv", got, 8'h00);

        // R2 R3 write and readback
        wr(2'd1, 8'hA5); wr(2'd2, 8'h3C); wr(2'd3, 8'h5A);
        check("R2 pin_oe", pin_oe, 8'hA5);
        check("R2 pin_out", pin_out, 8'hA5);
        rd(2'd1, got); check("R3 drive", got, 8'hA5);
        rd(2'd2, got); check("R3 inv", got, 8'h3C);
        rd(2'd3, got); check("R3 dir", got, 8'h5A);
        cyc(2); check("R3 rd_data holds", rd_data, 8'h5A);

        // R4 write to index 0 ignored
        wr(2'd0, 8'h00);
        check("R4 pin_oe", pin_oe, 8'hA5);
        check("R4 pin_out", pin_out, 8'hA5);
        rd(2'd1, got); check("R4 drive", got, 8'hA5);
        rd(2'd2, got); check("R4 inv", got, 8'h3C);
        rd(2'd3, got); check("R4 dir", got, 8'h5A);

        // R5 synchronizer depth
        do_reset();
        pin_in = 8'h55;
        cyc(1);
        rd(2'd0, got); check("R5 second edge old", got, 8'h00);
        rd(2'd0, got); check("R5 third edge new", got, 8'h55);

        // R5 inversion
        wr(2'd2, 8'h0F);
        pin_in = 8'h33; cyc(2);
        rd(2'd0, got); check("R5 inverted read", got, 8'h3C);

        // table walk: R6 R7 R8 R9
        do_reset();
        for (int i = 0; i < 8; i++) begin
            logic       do_rd;
            logic [7:0] dirv, pv;
            logic       exp_irq;
            {do_rd, dirv, pv, exp_irq} = VEC[i];
            wr(2'd3, dirv);
            pin_in = pv;
            cyc(2);
            check("R6 R7 R9 irq_n row", {7'd0, irq_n}, {7'd0, exp_irq});
            if (do_rd) begin
                rd(2'd0, got);
                check("R5 table read", got, pv);
                check("R8 clear on read", {7'd0, irq_n}, 8'h01);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule